// File: doc/BRIEF.md
# Multi-FIFO Inter-Processor Mailbox

This peripheral lets processors exchange 32-bit words through a shared pool of small hardware FIFOs. A sender writes a word into a FIFO's message register, and the receiver reads the same register to take the oldest word out. For every FIFO there is a register that shows whether it is full and a register that holds its pending-entry count. Processors can therefore poll instead of waiting for an interrupt.

Each processor that takes interrupts is a "user". A user has its own status and enable bits and its own interrupt line. Every FIFO drives two events into every user. One is "new message", raised on each accepted push. The other is "not full", raised when a pop frees a slot in a FIFO that was full. Software acknowledges an event by writing one to its status bit. It turns on sources by writing the enable register, and it turns off single sources through a separate enable-clear register.

Register access uses a single-cycle bus. Read data is combinational in the cycle the strobe is high, and a read of a message register pops the FIFO at that clock edge.

Top module: `mailbox_ctrl`

## Requirements
- R1: After reset every FIFO is empty, every user's status and enable bits are zero, and every interrupt output is low.
- R2: Offset 0x000 reads the constant parameter REV. Writes to it have no effect.
- R3: A write to 0x040+4*m stores the word in FIFO m. A read of that offset returns and removes the oldest stored word, so words come out in the order they went in.
- R4: Offset 0x080+4*m reads 1 while FIFO m holds DEPTH words and 0 otherwise.
- R5: Offset 0x0C0+4*m returns the number of words in FIFO m, zero-extended. This is 0 exactly when the FIFO is empty.
- R6: A write to a full FIFO is dropped. Contents and count stay unchanged.
- R7: A read of an empty FIFO's message register returns 0 and leaves the count at 0.
- R8: Each accepted push into FIFO m sets status bit 2*m in every user.
- R9: A pop that takes FIFO m from DEPTH words to DEPTH-1 sets status bit 2*m+1 in every user.
- R10: The status register of user u is at 0x104+0x10*u. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Writing 0x108+0x10*u loads user u's enable bits. Writing 1s to 0x10C+0x10*u clears the matching enable bits. Both offsets read back the enable bits.
- R12: irq[u] is high exactly while user u has a status bit that is also enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high and bus_wr is low |
| irq | output | NUSER | One interrupt line per user |

## Verification
Directed sequences fill a FIFO to its limit, push once more, and then drain it below empty. This tests drop-on-full and zero-on-empty, and shows that the not-full event fires only when a pop leaves the full state. Status and enable writes use mixed bit patterns, including all-zero writes, to show that set, clear and acknowledge each touch only the bits they name. A long pseudo-random mix of pushes, pops and register writes across all FIFOs and users is then compared, access by access, against a queue-based model. This exposes cross-FIFO and cross-user interference that the directed cases cannot reach.

// File: rtl/mailbox_ctrl.sv
module mailbox_ctrl #(
  parameter int NFIFO = 4,
  parameter int NUSER = 3,
  parameter int DEPTH = 4,
  parameter logic [31:0] REV = 32'h0000_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUSER-1:0]  irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 2 * NFIFO;

  logic [31:0]   mem  [NFIFO][DEPTH];
  logic [PW-1:0] wp   [NFIFO];
  logic [PW-1:0] rp   [NFIFO];
  logic [CW-1:0] cnt  [NFIFO];
  logic [EW-1:0] stat [NUSER];
  logic [EW-1:0] ena  [NUSER];

  wire       aln   = bus_addr[1:0] == 2'b00;
  wire       rd    = bus_en & ~bus_wr;
  wire       wr    = bus_en & bus_wr;
  wire [1:0] grp   = bus_addr[7:6];
  wire [3:0] idx   = bus_addr[5:2];
  wire [3:0] usr   = bus_addr[7:4];
  wire [1:0] sub   = bus_addr[3:2];
  wire       f_area = aln && bus_addr[11:8] == 4'h0;
  wire       u_area = aln && bus_addr[11:8] == 4'h1;

  logic [NFIFO-1:0] rd_sel, wr_sel, push_ok, pop_ok, is_full;
  logic [NUSER-1:0] stat_wr, ena_wr, ena_clr;
  logic [EW-1:0]    evset;

  always_comb begin
    for (int m = 0; m < NFIFO; m++) begin
      is_full[m]  = cnt[m] == CW'(DEPTH);
      rd_sel[m]   = rd && f_area && grp == 2'd1 && idx == 4'(m);
      wr_sel[m]   = wr && f_area && grp == 2'd1 && idx == 4'(m);
      push_ok[m]  = wr_sel[m] && !is_full[m];
      pop_ok[m]   = rd_sel[m] && cnt[m] != '0;
      evset[2*m]   = push_ok[m];
      evset[2*m+1] = pop_ok[m] && is_full[m];
    end
    for (int u = 0; u < NUSER; u++) begin
      stat_wr[u] = wr && u_area && usr == 4'(u) && sub == 2'd1;
      ena_wr[u]  = wr && u_area && usr == 4'(u) && sub == 2'd2;
      ena_clr[u] = wr && u_area && usr == 4'(u) && sub == 2'd3;
    end
  end

  always_ff @(posedge clk) begin
    for (int m = 0; m < NFIFO; m++)
      if (push_ok[m]) mem[m][wp[m]] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NFIFO; m++) begin
        wp[m] <= '0; rp[m] <= '0; cnt[m] <= '0;
      end
      for (int u = 0; u < NUSER; u++) begin
        stat[u] <= '0; ena[u] <= '0;
      end
    end else begin
      for (int m = 0; m < NFIFO; m++) begin
        if (push_ok[m]) begin
          wp[m]  <= (wp[m] == PW'(DEPTH-1)) ? '0 : wp[m] + 1'b1;
          cnt[m] <= cnt[m] + 1'b1;
        end else if (pop_ok[m]) begin
          rp[m]  <= (rp[m] == PW'(DEPTH-1)) ? '0 : rp[m] + 1'b1;
          cnt[m] <= cnt[m] - 1'b1;
        end
      end
      for (int u = 0; u < NUSER; u++) begin
        stat[u] <= (stat[u] & ~(stat_wr[u] ? bus_wdata[EW-1:0] : '0)) | evset;
        if (ena_wr[u])       ena[u] <= bus_wdata[EW-1:0];
        else if (ena_clr[u]) ena[u] <= ena[u] & ~bus_wdata[EW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (f_area) begin
      if (grp == 2'd0 && idx == 4'd0) bus_rdata = REV;
      for (int m = 0; m < NFIFO; m++)
        if (idx == 4'(m))
          case (grp)
            2'd1:    bus_rdata = (cnt[m] != '0) ? mem[m][rp[m]] : '0;
            2'd2:    bus_rdata = {31'b0, is_full[m]};
            2'd3:    bus_rdata = 32'(cnt[m]);
            default: ;
          endcase
    end else if (u_area) begin
      for (int u = 0; u < NUSER; u++)
        if (usr == 4'(u))
          case (sub)
            2'd1:    bus_rdata = 32'(stat[u]);
            2'd2,
            2'd3:    bus_rdata = 32'(ena[u]);
            default: ;
          endcase
    end
  end

  always_comb
    for (int u = 0; u < NUSER; u++) irq[u] = |(stat[u] & ena[u]);

  for (genvar m = 0; m < NFIFO; m++) begin : g_fifo_chk
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[m] <= CW'(DEPTH));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[m] && is_full[m]) |=> is_full[m]);
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel[m] && cnt[m] == '0) |=> cnt[m] == '0);
    for (genvar u = 0; u < NUSER; u++) begin : g_usr
      p_newmsg_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok[m] |=> stat[u][2*m]);
      p_notfull_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok[m] && is_full[m]) |=> stat[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NUSER; u++) begin : g_usr_chk
    for (genvar b = 0; b < EW; b++) begin : g_bit
      p_w1c_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr[u] && bus_wdata[b]) |=> !stat[u][b]);
      p_w0_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr[u] && !bus_wdata[b]) |=> stat[u][b] == $past(stat[u][b]));
    end
  end
endmodule

// File: tb/mailbox_ctrl_test.sv
module mailbox_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NF = 4, NU = 3, D = 4;
  localparam logic [31:0] REV = 32'h0000_0102;

  logic clk = 0, rst_n = 0, bus_en = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NU-1:0] irq;

  mailbox_ctrl #(.NFIFO(NF), .NUSER(NU), .DEPTH(D), .REV(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [31:0] q [NF][$];
  logic [31:0] mstat [NU];
  logic [31:0] mena  [NU];
  localparam logic [31:0] EMASK = (32'h1 << (2*NF)) - 1;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    int i, u;
    i = int'(a[5:2]); u = int'(a[7:4]);
    if (a[1:0] != 0) return 0;
    if (a[11:8] == 0) begin
      case (a[7:6])
        2'd0: return (i == 0) ? REV : 0;
        2'd1: return (i < NF && q[i].size() > 0) ? q[i][0] : 0;
        2'd2: return (i < NF && q[i].size() == D) ? 1 : 0;
        default: return (i < NF) ? q[i].size() : 0;
      endcase
    end
    if (a[11:8] == 1 && u < NU) begin
      case (a[3:2])
        2'd1: return mstat[u];
        2'd2, 2'd3: return mena[u];
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  task automatic model_update(bit w, logic [11:0] a, logic [31:0] d);
    int i, u;
    i = int'(a[5:2]); u = int'(a[7:4]);
    if (a[1:0] != 0) return;
    if (a[11:8] == 0 && a[7:6] == 2'd1 && i < NF) begin
      if (w) begin
        if (q[i].size() < D) begin
          q[i].push_back(d);
          for (int k = 0; k < NU; k++) mstat[k][2*i] = 1'b1;
        end
      end else if (q[i].size() > 0) begin
        if (q[i].size() == D)
          for (int k = 0; k < NU; k++) mstat[k][2*i+1] = 1'b1;
        void'(q[i].pop_front());
      end
    end else if (w && a[11:8] == 1 && u < NU) begin
      case (a[3:2])
        2'd1: mstat[u] = mstat[u] & ~(d & EMASK);
        2'd2: mena[u]  = d & EMASK;
        2'd3: mena[u]  = mena[u] & ~d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [NU-1:0] exp_irq();
    logic [NU-1:0] r;
    for (int k = 0; k < NU; k++) r[k] = |(mstat[k] & mena[k]);
    return r;
  endfunction

  task automatic op(bit w, logic [11:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    bus_en = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (!w) check(bus_rdata, exp_read(a), tag);
    @(posedge clk);
    model_update(w, a, d);
    #1;
    bus_en = 0;
    check(32'(irq), 32'(exp_irq()), {tag, " R12 irq"});
  endtask

  function automatic logic [11:0] msg(int m);  return 12'(12'h040 + 4*m); endfunction
  function automatic logic [11:0] full(int m); return 12'(12'h080 + 4*m); endfunction
  function automatic logic [11:0] cntr(int m); return 12'(12'h0C0 + 4*m); endfunction
  function automatic logic [11:0] st(int u);   return 12'(12'h104 + 16*u); endfunction
  function automatic logic [11:0] en(int u);   return 12'(12'h108 + 16*u); endfunction
  function automatic logic [11:0] ec(int u);   return 12'(12'h10C + 16*u); endfunction

  initial begin
    #(CLK_P * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < NU; k++) begin mstat[k] = 0; mena[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check(32'(irq), 0, "R1 irq after reset");
    for (int m = 0; m < NF; m++) op(0, cntr(m), 0, "R1 count after reset");
    for (int u = 0; u < NU; u++) begin
      op(0, st(u), 0, "R1 status after reset");
      op(0, en(u), 0, "R1 enable after reset");
    end
    // R2 revision
    op(0, 12'h000, 0, "R2 revision");
    op(1, 12'h000, 32'hFFFF_FFFF, "R2 write revision");
    op(0, 12'h000, 0, "R2 revision after write");
    // R11 enable load
    op(1, en(0), 32'hFF, "R11 enable write");
    op(0, en(0), 0, "R11 enable read");
    op(0, ec(0), 0, "R11 enable via clear offset");
    // R3 / R8 pushes
    op(1, msg(0), 32'hA1, "R3 push");
    op(1, msg(0), 32'hA2, "R3 push");
    op(1, msg(0), 32'hA3, "R3 push");
    op(0, st(1), 0, "R8 newmsg in user1");
    op(0, st(2), 0, "R8 newmsg in user2");
    op(0, cntr(0), 0, "R5 count 3");
    op(0, full(0), 0, "R4 not full");
    // R10 W1C
    op(1, st(0), 32'h0, "R10 write zero");
    op(0, st(0), 0, "R10 unchanged");
    op(1, st(0), 32'h1, "R10 write one");
    op(0, st(0), 0, "R10 cleared");
    // R4 / R6 full and drop
    op(1, msg(0), 32'hA4, "R3 push");
    op(0, full(0), 0, "R4 full");
    op(1, msg(0), 32'hDEAD, "R6 push to full");
    op(0, cntr(0), 0, "R6 count unchanged");
    op(0, full(0), 0, "R6 still full");
    // R3 / R9 drain
    op(0, msg(0), 0, "R3 pop order");
    op(0, st(2), 0, "R9 notfull in user2");
    op(0, st(0), 0, "R9 notfull in user0");
    op(0, msg(0), 0, "R3 pop order");
    op(0, msg(0), 0, "R3 pop order");
    op(0, msg(0), 0, "R3 pop order");
    // R7 empty
    op(0, msg(0), 0, "R7 pop empty");
    op(0, cntr(0), 0, "R7 count stays 0");
    // R11 enable clear
    op(1, ec(0), 32'h2, "R11 clear bit1");
    op(0, en(0), 0, "R11 after clear");
    op(1, ec(0), 32'h0, "R11 clear zero");
    op(0, en(0), 0, "R11 after zero clear");
    // R12 other user, other FIFO
    op(1, en(2), 32'h40, "R12 enable user2 fifo3 newmsg");
    op(1, st(2), 32'hFF, "R10 clear all user2");
    op(1, msg(3), 32'h33, "R12 push fifo3");
    op(0, msg(3), 0, "R3 fifo3 pop");
    op(1, st(2), 32'h40, "R12 ack user2");
    // mixed traffic
    for (int k = 0; k < 1500; k++) begin
      int r, m, u;
      r = int'($urandom % 8); m = int'($urandom % NF); u = int'($urandom % NU);
      case (r)
        0, 1: op(1, msg(m), $urandom, "R3 mix push");
        2, 3: op(0, msg(m), 0, "R3 mix pop");
        4:    op(0, cntr(m), 0, "R5 mix count");
        5:    op(1, st(u), $urandom, "R10 mix ack");
        6:    op(1, ($urandom % 2) ? en(u) : ec(u), $urandom, "R11 mix enable");
        default: op(0, (m % 2) ? st(u) : full(m), 0, "R4 mix read");
      endcase
    end
    summary();
    $finish;
  end
endmodule